// File: doc/BRIEF.md
# Three-Channel Colour Matrix Converter

This block converts a stream of three-channel pixels from one colour space to another. Each output channel is a weighted sum of the three input channels plus a constant, so the whole conversion is a 3-row by 4-column matrix. The first three columns are signed multipliers in S2.13 format and the fourth column is a signed S0.13 offset measured as a fraction of full scale. Every input and output channel is a 14-bit unsigned fraction of full scale.

A per-pixel mode input picks the matrix. It can be the identity (bypass), one of three built-in conversions (limited-range RGB, standard-definition YCbCr and high-definition YCbCr), or a user set loaded through six 32-bit configuration writes. Configuration writes land in a shadow copy and are moved into the working copy only on a frame-start strobe, so a frame never sees a half-loaded matrix. An enable input forces pass-through regardless of mode. Pixels enter with a valid strobe and leave, with their own valid, exactly three clock cycles later.

Top module: `csc_matrix3x4`

## Requirements
- R1: For each row k, the block forms acc = in_c0*Ck1 + in_c1*Ck2 + in_c2*Ck3 + Ck4_off*16384 + 4096 using signed arithmetic, where multipliers are 16-bit two's complement (1.0 = 8192) and Ck4_off is the offset value defined in R2. out_ck = floor(acc / 8192), limited as in R6.
- R2: Configuration register n (cfg_idx = 0..5) holds two coefficients: bits [15:0] the first and bits [31:16] the second of the pairs C11/C12, C13/C14, C21/C22, C23/C24, C31/C32, C33/C34 for n = 0..5. For the column-4 offsets only bits [13:0] count, read as a two's-complement S0.13 value; bits [15:14] are ignored. Writes with cfg_idx 6 or 7 change nothing.
- R3: Configuration writes go into a shadow copy; the working user matrix takes the whole shadow copy only on a cycle with frame_start high. A write in that same cycle lands in the shadow copy for the following frame start, and a pixel accepted in that cycle uses the working matrix in force before it.
- R4: csc_mode is sampled with each pixel: 0 = identity, 1 = limited-range RGB, 2 = standard-definition YCbCr, 3 = high-definition YCbCr, 4 = working user matrix, 5..7 = identity. The identity matrix has 8192 on the diagonal and zero elsewhere, so the output equals the input.
- R5: A pixel accepted with csc_en low leaves the block unchanged, whatever csc_mode holds.
- R6: A row result below zero is output as 0 and a result above 16383 is output as 16383.
- R7: out_valid rises exactly three cycles after the cycle in which in_valid is sampled high, one output per input, and the output channels keep their last value while no result is produced.
- R8: After reset out_valid is 0, all output channels are 0 and both the shadow and working user matrices are all zero.
- R9: The built-in matrices, rows listed as (C1, C2, C3, offset): mode 1 rows (7035,0,0,512), (0,7035,0,512), (0,0,7035,512); mode 2 rows (2104,4130,802,512), (-1214,-2384,3598,4096), (3598,-3013,-585,4096); mode 3 rows (1496,5032,508,512), (-824,-2774,3598,4096), (3598,-3268,-330,4096).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frame_start | input | 1 | Moves the shadow user matrix into the working copy |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 3 | Configuration register index |
| cfg_wdata | input | 32 | Configuration write data, two coefficients |
| csc_en | input | 1 | Matrix enable; low forces pass-through |
| csc_mode | input | 3 | Matrix select, sampled with each pixel |
| in_valid | input | 1 | Input pixel strobe |
| in_c0 | input | 14 | Input channel 0 |
| in_c1 | input | 14 | Input channel 1 |
| in_c2 | input | 14 | Input channel 2 |
| out_valid | output | 1 | Output pixel strobe |
| out_c0 | output | 14 | Output channel 0 (matrix row 1) |
| out_c1 | output | 14 | Output channel 1 (matrix row 2) |
| out_c2 | output | 14 | Output channel 2 (matrix row 3) |

## Verification
The assertions assume that the configuration and mode inputs are stable and known in every cycle after reset, and that rst_n is held low long enough for the internal reset stage to clear. The latency and pass-through properties look three cycles back, so they rely on a post-reset cycle counter rather than on the inputs seen during reset. The stimulus drives every input on the falling edge, keeps in_valid low throughout reset, and only issues pixels, writes and frame starts after the internal reset has been released.

// File: rtl/csc_pkg.sv
package csc_pkg;

  localparam int CSC_CW    = 16;
  localparam int CSC_NCOEF = 12;
  localparam int CSC_NREG  = CSC_NCOEF / 2;
  localparam int CSC_ONE   = 8192;

  // Coefficients in row-major order: index 4*row + column.
  typedef logic [CSC_NCOEF-1:0][CSC_CW-1:0] csc_mat_t;

  localparam logic [2:0] CSC_M_IDENT = 3'd0;
  localparam logic [2:0] CSC_M_TVRGB = 3'd1;
  localparam logic [2:0] CSC_M_SD    = 3'd2;
  localparam logic [2:0] CSC_M_HD    = 3'd3;
  localparam logic [2:0] CSC_M_USER  = 3'd4;

  function automatic csc_mat_t csc_row_set(input csc_mat_t m, input int row,
                                           input int a, input int b,
                                           input int c, input int o);
    csc_mat_t r;
    r = m;
    r[4*row+0] = CSC_CW'(a);
    r[4*row+1] = CSC_CW'(b);
    r[4*row+2] = CSC_CW'(c);
    r[4*row+3] = CSC_CW'(o);
    return r;
  endfunction

  // Fixed matrices; anything not listed is the identity.
  function automatic csc_mat_t csc_preset(input logic [2:0] mode);
    csc_mat_t m;
    m = '0;
    case (mode)
      CSC_M_TVRGB: begin
        m = csc_row_set(m, 0, 7035, 0, 0, 512);
        m = csc_row_set(m, 1, 0, 7035, 0, 512);
        m = csc_row_set(m, 2, 0, 0, 7035, 512);
      end
      CSC_M_SD: begin
        m = csc_row_set(m, 0, 2104, 4130, 802, 512);
        m = csc_row_set(m, 1, -1214, -2384, 3598, 4096);
        m = csc_row_set(m, 2, 3598, -3013, -585, 4096);
      end
      CSC_M_HD: begin
        m = csc_row_set(m, 0, 1496, 5032, 508, 512);
        m = csc_row_set(m, 1, -824, -2774, 3598, 4096);
        m = csc_row_set(m, 2, 3598, -3268, -330, 4096);
      end
      default: begin
        m = csc_row_set(m, 0, CSC_ONE, 0, 0, 0);
        m = csc_row_set(m, 1, 0, CSC_ONE, 0, 0);
        m = csc_row_set(m, 2, 0, 0, CSC_ONE, 0);
      end
    endcase
    return m;
  endfunction

endpackage

// File: rtl/csc_coef_bank.sv
module csc_coef_bank
  import csc_pkg::*;
#(
  parameter int NREG  = CSC_NREG,
  parameter int REG_W = 2 * CSC_CW,
  localparam int IDX_W = $clog2(NREG + 2)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        frame_start,
  input  logic                        cfg_we,
  input  logic [IDX_W-1:0]            cfg_idx,
  input  logic [REG_W-1:0]            cfg_wdata,
  output logic [NREG-1:0][REG_W-1:0]  active
);

  logic [NREG-1:0][REG_W-1:0] shadow_q, shadow_d;
  logic [NREG-1:0][REG_W-1:0] active_q, active_d;
  logic                       wr_hit;

  assign wr_hit = cfg_we && (cfg_idx < IDX_W'(NREG));

  always_comb begin
    shadow_d = shadow_q;
    if (wr_hit) shadow_d[cfg_idx] = cfg_wdata;
    active_d = frame_start ? shadow_q : active_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      active_q <= '0;
    end else begin
      if (wr_hit)      shadow_q <= shadow_d;
      if (frame_start) active_q <= active_d;
    end
  end

  assign active = active_q;

  // R3: the working set moves only on a frame start
  a_r3_hold_between_frames: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(active_q));

  // R3: a frame start copies the shadow contents seen in that cycle
  a_r3_load_on_frame: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> active_q == $past(shadow_q));

endmodule

// File: rtl/csc_row.sv
module csc_row #(
  parameter int DATA_W = 14,
  parameter int CW     = 16,
  parameter int FRAC_W = 13,
  localparam int PW    = DATA_W + 1 + CW,
  localparam int ACC_W = PW + 2,
  localparam int OFF_W = FRAC_W + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en_s1,
  input  logic                     en_s2,
  input  logic                     en_s3,
  input  logic [2:0][DATA_W-1:0]   pix,
  input  logic [3:0][CW-1:0]       coef,
  output logic [DATA_W-1:0]        res
);

  localparam logic signed [ACC_W-1:0] HALF_LSB = ACC_W'(1) <<< (FRAC_W - 1);
  localparam logic signed [ACC_W-1:0] MAX_V    = ACC_W'((1 << DATA_W) - 1);

  logic signed [PW-1:0]    prod_d [3];
  logic signed [PW-1:0]    prod_q [3];
  logic signed [ACC_W-1:0] off_d, off_q;
  logic signed [ACC_W-1:0] sum_d, sum_q;
  logic signed [ACC_W-1:0] scaled;
  logic [DATA_W-1:0]       res_d, res_q;
  logic signed [OFF_W-1:0] off_raw;
  logic                    off_unused;

  assign off_raw    = coef[3][OFF_W-1:0];
  assign off_unused = ^coef[3][CW-1:OFF_W];

  // stage 1: products and offset alignment
  always_comb begin
    for (int j = 0; j < 3; j++)
      prod_d[j] = $signed({1'b0, pix[j]}) * $signed(coef[j]);
    off_d = {{(ACC_W-OFF_W){off_raw[OFF_W-1]}}, off_raw} <<< DATA_W;
  end

  // stage 2: accumulate with rounding
  always_comb begin
    sum_d = off_q + HALF_LSB;
    for (int j = 0; j < 3; j++)
      sum_d = sum_d + {{(ACC_W-PW){prod_q[j][PW-1]}}, prod_q[j]};
  end

  // stage 3: scale back and limit
  always_comb begin
    scaled = sum_q >>> FRAC_W;
    if (scaled < 0)          res_d = '0;
    else if (scaled > MAX_V) res_d = '1;
    else                     res_d = scaled[DATA_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < 3; j++) prod_q[j] <= '0;
      off_q <= '0;
      sum_q <= '0;
      res_q <= '0;
    end else begin
      if (en_s1) begin
        for (int j = 0; j < 3; j++) prod_q[j] <= prod_d[j];
        off_q <= off_d;
      end
      if (en_s2) sum_q <= sum_d;
      if (en_s3) res_q <= res_d;
    end
  end

  assign res = res_q;

  // R7: output holds while no result is produced
  a_r7_row_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en_s3 |=> $stable(res_q));

endmodule

// File: rtl/csc_matrix3x4.sv
module csc_matrix3x4
  import csc_pkg::*;
#(
  parameter int DATA_W = 14,
  parameter int FRAC_W = 13,
  localparam int REG_W = 2 * CSC_CW,
  localparam int IDX_W = $clog2(CSC_NREG + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [REG_W-1:0]  cfg_wdata,
  input  logic              csc_en,
  input  logic [2:0]        csc_mode,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_c0,
  input  logic [DATA_W-1:0] in_c1,
  input  logic [DATA_W-1:0] in_c2,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_c0,
  output logic [DATA_W-1:0] out_c1,
  output logic [DATA_W-1:0] out_c2
);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [CSC_NREG-1:0][REG_W-1:0] active_regs;
  csc_mat_t                       mat_user, mat_sel;
  logic [2:0][DATA_W-1:0]         pix;
  logic [2:0][DATA_W-1:0]         res;
  logic [2:0]                     vld_q, vld_d;

  csc_coef_bank #(.NREG(CSC_NREG), .REG_W(REG_W)) u_bank (
    .clk(clk), .rst_n(rst_int_n), .frame_start(frame_start),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .active(active_regs)
  );

  // Register n low half is coefficient 2n, high half 2n+1.
  assign mat_user = active_regs;
  assign pix      = {in_c2, in_c1, in_c0};

  always_comb begin
    if (!csc_en)                   mat_sel = csc_preset(CSC_M_IDENT);
    else if (csc_mode == CSC_M_USER) mat_sel = mat_user;
    else                           mat_sel = csc_preset(csc_mode);
  end

  for (genvar k = 0; k < 3; k++) begin : g_row
    csc_row #(.DATA_W(DATA_W), .CW(CSC_CW), .FRAC_W(FRAC_W)) u_row (
      .clk(clk), .rst_n(rst_int_n),
      .en_s1(in_valid), .en_s2(vld_q[0]), .en_s3(vld_q[1]),
      .pix(pix), .coef(mat_sel[4*k +: 4]), .res(res[k])
    );
  end

  assign vld_d = {vld_q[1:0], in_valid};

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) vld_q <= '0;
    else            vld_q <= vld_d;
  end

  assign out_valid = vld_q[2];
  assign out_c0    = res[0];
  assign out_c1    = res[1];
  assign out_c2    = res[2];

  // Cycles since reset release, saturating, so history checks stay inside it.
  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)       age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  logic pass_req;
  assign pass_req = !csc_en || (csc_mode == CSC_M_IDENT) || (csc_mode > CSC_M_USER);

  // R7: one output three cycles after each input
  a_r7_latency: assert property (@(posedge clk) disable iff (!rst_int_n)
    (age_q == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  // R5/R4: pass-through pixels leave unchanged
  a_r5_pass_through: assert property (@(posedge clk) disable iff (!rst_int_n)
    ((age_q == 2'd3) && $past(in_valid && pass_req, 3))
      |-> ({out_c2, out_c1, out_c0} == $past(pix, 3)));

endmodule

// File: tb/csc_matrix3x4_test.sv
module csc_matrix3x4_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_start = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic [31:0] cfg_wdata = '0;
  logic        csc_en = 1'b0;
  logic [2:0]  csc_mode = '0;
  logic        in_valid = 1'b0;
  logic [13:0] in_c0 = '0, in_c1 = '0, in_c2 = '0;
  logic        out_valid;
  logic [13:0] out_c0, out_c1, out_c2;

  csc_matrix3x4 uut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .cfg_we(cfg_we),
    .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .csc_en(csc_en), .csc_mode(csc_mode),
    .in_valid(in_valid), .in_c0(in_c0), .in_c1(in_c1), .in_c2(in_c2),
    .out_valid(out_valid), .out_c0(out_c0), .out_c1(out_c1), .out_c2(out_c2)
  );

  always #10 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit mon_on = 0;
  bit done = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // spec tables (R4, R9)
  int t_id [12] = '{8192,0,0,0, 0,8192,0,0, 0,0,8192,0};
  int t_tv [12] = '{7035,0,0,512, 0,7035,0,512, 0,0,7035,512};
  int t_sd [12] = '{2104,4130,802,512, -1214,-2384,3598,4096, 3598,-3013,-585,4096};
  int t_hd [12] = '{1496,5032,508,512, -824,-2774,3598,4096, 3598,-3268,-330,4096};

  logic [31:0] sh_r [6];
  logic [31:0] act_r [6];

  typedef struct { int c0; int c1; int c2; int cyc; } exp_t;
  exp_t  expq [$];
  string tagq [$];
  int last0 = 0, last1 = 0, last2 = 0;

  function automatic int s16(logic [15:0] v);
    return v[15] ? int'(v) - 65536 : int'(v);
  endfunction

  function automatic int s14(logic [15:0] v);
    int t;
    t = int'(v[13:0]);
    return v[13] ? t - 16384 : t;
  endfunction

  function automatic logic [15:0] coef_of(int mode, bit en, int idx);
    if (!en) return 16'(t_id[idx]);
    case (mode)
      1: return 16'(t_tv[idx]);
      2: return 16'(t_sd[idx]);
      3: return 16'(t_hd[idx]);
      4: return (idx % 2 == 0) ? act_r[idx/2][15:0] : act_r[idx/2][31:16];
      default: return 16'(t_id[idx]);
    endcase
  endfunction

  function automatic int row_val(int k, int p0, int p1, int p2, int mode, bit en);
    longint acc;
    acc = longint'(p0) * s16(coef_of(mode, en, 4*k))
        + longint'(p1) * s16(coef_of(mode, en, 4*k+1))
        + longint'(p2) * s16(coef_of(mode, en, 4*k+2))
        + longint'(s14(coef_of(mode, en, 4*k+3))) * 16384 + 4096;
    acc = acc >>> 13;
    if (acc < 0) return 0;
    if (acc > 16383) return 16383;
    return int'(acc);
  endfunction

  task automatic check(bit ok, string tag, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic send_pix(int p0, int p1, int p2, int mode, bit en, bit fs, string tag);
    exp_t e;
    in_valid = 1'b1; in_c0 = 14'(p0); in_c1 = 14'(p1); in_c2 = 14'(p2);
    csc_mode = 3'(mode); csc_en = en; frame_start = fs;
    e.c0 = row_val(0, p0, p1, p2, mode, en);
    e.c1 = row_val(1, p0, p1, p2, mode, en);
    e.c2 = row_val(2, p0, p1, p2, mode, en);
    e.cyc = cyc + 3;
    expq.push_back(e);
    tagq.push_back(tag);
    if (fs) act_r = sh_r;
    @(negedge clk);
    in_valid = 1'b0; frame_start = 1'b0;
  endtask

  task automatic tick_cfg(bit fs, bit we, int idx, logic [31:0] d);
    frame_start = fs; cfg_we = we; cfg_idx = 3'(idx); cfg_wdata = d;
    if (fs) act_r = sh_r;
    if (we && idx < 6) sh_r[idx] = d;
    @(negedge clk);
    frame_start = 1'b0; cfg_we = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (mon_on && out_valid) begin
      if (expq.size() == 0) begin
        check(1'b0, "R7 unexpected output", 1, 0);
      end else begin
        exp_t e;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        n_chk++;
        if (out_c0 != 14'(e.c0) || out_c1 != 14'(e.c1) || out_c2 != 14'(e.c2) || cyc != e.cyc) begin
          n_bad++;
          $display("FAIL %s: actual %0d/%0d/%0d @%0d expected %0d/%0d/%0d @%0d",
                   t, out_c0, out_c1, out_c2, cyc, e.c0, e.c1, e.c2, e.cyc);
        end
        last0 = e.c0; last1 = e.c1; last2 = e.c2;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int seed;
    for (int i = 0; i < 6; i++) begin sh_r[i] = '0; act_r[i] = '0; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R8: reset state
    check(out_valid == 1'b0, "R8 out_valid", int'(out_valid), 0);
    check(out_c0 == 0 && out_c1 == 0, "R8 out_c0/c1", int'(out_c0) + int'(out_c1), 0);
    check(out_c2 == 0, "R8 out_c2", int'(out_c2), 0);
    mon_on = 1;
    // R8: user matrix cleared by reset
    send_pix(5000, 9000, 16383, 4, 1, 0, "R8 user set zero");
    // R4: identity modes
    send_pix(0, 0, 0, 0, 1, 0, "R4 mode0 black");
    send_pix(16383, 16383, 16383, 0, 1, 0, "R4 mode0 white");
    send_pix(1234, 8000, 15000, 0, 1, 0, "R4 mode0 mixed");
    send_pix(321, 654, 987, 5, 1, 0, "R4 mode5");
    send_pix(16000, 12, 777, 6, 1, 0, "R4 mode6");
    send_pix(4096, 8192, 12288, 7, 1, 0, "R4 mode7");
    // R5: disable overrides mode
    send_pix(1000, 2000, 3000, 3, 0, 0, "R5 en off mode3");
    send_pix(16383, 0, 8191, 4, 0, 0, "R5 en off mode4");
    // R9: built-in matrices
    for (int m = 1; m <= 3; m++) begin
      send_pix(16383, 16383, 16383, m, 1, 0, "R9 preset white");
      send_pix(0, 0, 0, m, 1, 0, "R9 preset black");
      send_pix(16383, 0, 0, m, 1, 0, "R9 preset red");
      send_pix(0, 0, 16383, m, 1, 0, "R9 preset blue");
      send_pix(8192, 4000, 12000, m, 1, 0, "R9 preset mid");
    end
    // R2: load user matrix (offset bits 15:14 set on row 1)
    tick_cfg(0, 1, 0, {16'h0000, 16'h2000});
    tick_cfg(0, 1, 1, {16'hC100, 16'h0000});
    tick_cfg(0, 1, 2, {16'h0000, 16'h4000});
    tick_cfg(0, 1, 3, {16'h0000, 16'h0000});
    tick_cfg(0, 1, 4, {16'h1000, 16'hE000});
    tick_cfg(0, 1, 5, {16'h3000, 16'h0000});
    // R3: not yet in force
    send_pix(9000, 9000, 9000, 4, 1, 0, "R3 before frame start");
    // R3: frame start with a simultaneous write; the write waits a frame
    tick_cfg(1, 1, 0, {16'h0000, 16'h1000});
    send_pix(9000, 100, 0, 4, 1, 0, "R2 user matrix");
    send_pix(16383, 16383, 0, 4, 1, 0, "R6 clamp high and low");
    send_pix(0, 16383, 0, 4, 1, 0, "R6 user row3");
    send_pix(20, 300, 5000, 4, 1, 0, "R1 user small");
    // R3: pixel in a frame-start cycle uses the old set
    send_pix(8000, 2000, 100, 4, 1, 1, "R3 pixel on frame start");
    send_pix(8000, 2000, 100, 4, 1, 0, "R3 after frame start");
    // R2: indices 6 and 7 ignored
    tick_cfg(0, 1, 6, 32'hFFFF_FFFF);
    tick_cfg(0, 1, 7, 32'h1234_5678);
    tick_cfg(1, 0, 0, 32'h0);
    send_pix(7000, 7000, 7000, 4, 1, 0, "R2 idx6/7 ignored");
    // R1: back-to-back stream, mixed modes
    seed = 17;
    for (int i = 0; i < 40; i++) begin
      int a, b, c;
      seed = seed * 1103515245 + 12345; a = (seed >>> 8) & 16383;
      seed = seed * 1103515245 + 12345; b = (seed >>> 8) & 16383;
      seed = seed * 1103515245 + 12345; c = (seed >>> 8) & 16383;
      send_pix(a, b, c, i % 8, (i % 5) != 0, 0, "R1 stream");
    end
    // R7: drain and hold
    repeat (8) @(negedge clk);
    check(expq.size() == 0, "R7 all results delivered", expq.size(), 0);
    check(out_valid == 1'b0, "R7 idle valid", int'(out_valid), 0);
    check(int'(out_c0) == last0 && int'(out_c1) == last1 && int'(out_c2) == last2,
          "R7 outputs hold", int'(out_c0), last0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule